// File: doc/BRIEF.md
# Banked CPU Register File with Bank Exchange

This block is the programmer-visible register storage of an 8-bit processor datapath. It keeps an accumulator and a flag byte, six general-purpose bytes named B, C, D, E, H and L, two 16-bit index registers (IX, IY) and a 16-bit stack pointer. The accumulator/flag group and the six general-purpose bytes each exist twice, as an active set and an alternate set. The index registers and the stack pointer exist once.

Two read ports and one write port address the storage either one byte at a time or as 16-bit pairs. Two exchange strobes swap the active and alternate sets. One swaps the accumulator/flag pair. The other swaps the BC, DE and HL pairs together. Each strobe flips a bank-select flip-flop, so no data moves and a swap costs one clock edge. The datapath decoder drives the selects and strobes. The ALU reads operands through the two ports.

Top module: `regfile_xchg`

## Requirements
- R1: While reset (rstN low, asynchronous) is held, and directly after it is released, every byte and pair reads 0, and both bank selects start at the first bank.
- R2: In byte mode (wide=0) the 4-bit select picks one byte. The codes are B=0, C=1, D=2, E=3, H=4, L=5, A=6, F=7, IX high=8, IX low=9, IY high=10, IY low=11, SP high=12, SP low=13. A byte write stores wrData[7:0].
- R3: In pair mode (wide=1) select code p (0..6) picks BC, DE, HL, AF, IX, IY or SP in that order. The pair is formed from byte codes 2p (the high byte, i.e. B, D, H or A) and 2p+1 (the low byte). A pair write stores wrData[15:8] in the high byte and wrData[7:0] in the low byte.
- R4: Both read ports work independently and at the same time, each with its own select and width.
- R5: Reads are combinational from the current state. A write becomes visible only after the rising clock edge at which wrEn is high.
- R6: An AF exchange (exAf) swaps the active AF pair with its alternate and leaves BC, DE, HL, IX, IY and SP unchanged.
- R7: A register exchange (exGp) swaps BC, DE and HL with their alternates at the same time and leaves AF unchanged.
- R8: IX, IY and SP are not banked. Neither exchange changes them.
- R9: Two exchanges of the same kind restore the original view. With AF=9900h and alternate 5944h, one AF exchange makes AF read 5944h and a second one makes it read 9900h again.
- R10: When a write and an exchange fall in the same cycle, the write lands in the bank that was active before the swap. After that edge the written value sits in the alternate set.
- R11: Unused codes (byte codes 14 and 15, pair codes with bit 3 set, pair code 7) read as 0, and writes to them change no register.
- R12: A byte read returns the byte on rdData[7:0] with rdData[15:8] = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| rdWideA | input | 1 | Port A: 1 = pair read, 0 = byte read |
| rdSelA | input | 4 | Port A register/pair select |
| rdDataA | output | 16 | Port A read data |
| rdWideB | input | 1 | Port B: 1 = pair read, 0 = byte read |
| rdSelB | input | 4 | Port B register/pair select |
| rdDataB | output | 16 | Port B read data |
| wrEn | input | 1 | Write strobe |
| wrWide | input | 1 | 1 = pair write, 0 = byte write |
| wrSel | input | 4 | Write register/pair select |
| wrData | input | 16 | Write data |
| exAf | input | 1 | Swap AF with its alternate |
| exGp | input | 1 | Swap BC, DE, HL with their alternates |

## Verification
Read data depends combinationally on the selects, so the bench changes a select and checks the port 1 ns later in the same cycle. A write or exchange driven before a rising edge appears on the ports straight after that edge. The bench therefore drives stimulus at the falling edge and checks at the following falling edge, once the single register stage has settled. For R5, the target register is also read before the edge to confirm it still holds its old value. After each write or exchange phase, the bench sweeps every select code in both widths on both ports against a bench model of the two banks.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

  localparam int NUM_GP  = 6;   // B C D E H L
  localparam int NUM_IDX = 6;   // IXh IXl IYh IYl SPh SPl
  localparam int NUM_SLOT = 16; // byte select space

  // Write strobes from control to datapath
  typedef struct packed {
    logic [NUM_GP-1:0]  gpWe;   // bit i = byte code i
    logic [1:0]         afWe;   // [0]=A (code 6), [1]=F (code 7)
    logic [NUM_IDX-1:0] idxWe;  // bit i = byte code 8+i
    logic               wide;   // pair write: even slot takes high data byte
    logic               togAf;
    logic               togGp;
  } wr_strobe_t;

endpackage

// File: rtl/regfile_ctrl.sv
module regfile_ctrl
  import regfile_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       wrWide,
  input  logic [3:0] wrSel,
  input  logic       exAf,
  input  logic       exGp,
  output wr_strobe_t strobe,
  output logic       afBank,
  output logic       gpBank
);

  localparam int NUM_WR_SLOT = NUM_GP + 2 + NUM_IDX;

  logic [NUM_WR_SLOT-1:0] byteWe;

  // Byte slot k is hit by byte code k or by pair code k/2
  always_comb begin
    for (int k = 0; k < NUM_WR_SLOT; k++) begin
      byteWe[k] = wrEn && (wrWide ? (!wrSel[3] && (wrSel[2:0] == 3'(k / 2)))
                                  : (wrSel == 4'(k)));
    end
  end

  always_comb begin
    strobe.gpWe  = byteWe[NUM_GP-1:0];
    strobe.afWe  = byteWe[NUM_GP+1:NUM_GP];
    strobe.idxWe = byteWe[NUM_WR_SLOT-1:NUM_GP+2];
    strobe.wide  = wrWide;
    strobe.togAf = exAf;
    strobe.togGp = exGp;
  end

  // Bank selects: exchange is a toggle, no data movement
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      afBank <= 1'b0;
      gpBank <= 1'b0;
    end else begin
      if (strobe.togAf) afBank <= ~afBank;
      if (strobe.togGp) gpBank <= ~gpBank;
    end
  end

endmodule

// File: rtl/regfile_dp.sv
module regfile_dp
  import regfile_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NUM_RD = 2
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  wr_strobe_t                      strobe,
  input  logic                            afBank,
  input  logic                            gpBank,
  input  logic [2*DATA_W-1:0]             wrData,
  input  logic [NUM_RD-1:0]               rdWide,
  input  logic [NUM_RD-1:0][3:0]          rdSel,
  output logic [NUM_RD-1:0][2*DATA_W-1:0] rdData
);

  localparam int PAIR_W = 2 * DATA_W;

  logic [DATA_W-1:0] gpMem  [2][NUM_GP];
  logic [DATA_W-1:0] afMem  [2][2];
  logic [DATA_W-1:0] idxMem [NUM_IDX];
  logic [DATA_W-1:0] view   [NUM_SLOT];
  logic [DATA_W-1:0] hiByte;
  logic [DATA_W-1:0] loByte;

  assign hiByte = strobe.wide ? wrData[PAIR_W-1:DATA_W] : wrData[DATA_W-1:0];
  assign loByte = wrData[DATA_W-1:0];

  // Banked storage: writes go to the bank active before any toggle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < 2; b++) begin
        for (int i = 0; i < NUM_GP; i++) gpMem[b][i] <= '0;
        for (int i = 0; i < 2; i++)      afMem[b][i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_GP; i++)
        if (strobe.gpWe[i]) gpMem[gpBank][i] <= (i % 2 == 0) ? hiByte : loByte;
      for (int i = 0; i < 2; i++)
        if (strobe.afWe[i]) afMem[afBank][i] <= (i == 0) ? hiByte : loByte;
    end
  end

  // Unbanked index registers and stack pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_IDX; i++) idxMem[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_IDX; i++)
        if (strobe.idxWe[i]) idxMem[i] <= (i % 2 == 0) ? hiByte : loByte;
    end
  end

  // Flat byte view of the active state, indexed by byte code
  always_comb begin
    for (int i = 0; i < NUM_GP; i++)  view[i] = gpMem[gpBank][i];
    view[NUM_GP]   = afMem[afBank][0];
    view[NUM_GP+1] = afMem[afBank][1];
    for (int i = 0; i < NUM_IDX; i++) view[NUM_GP+2+i] = idxMem[i];
    for (int i = NUM_GP + 2 + NUM_IDX; i < NUM_SLOT; i++) view[i] = '0;
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    always_comb begin
      if (rdWide[p]) begin
        if (rdSel[p][3]) rdData[p] = '0;
        else rdData[p] = {view[{rdSel[p][2:0], 1'b0}], view[{rdSel[p][2:0], 1'b1}]};
      end else begin
        rdData[p] = {{DATA_W{1'b0}}, view[rdSel[p]]};
      end
    end
  end

endmodule

// File: rtl/regfile_xchg.sv
module regfile_xchg
  import regfile_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rdWideA,
  input  logic [3:0]          rdSelA,
  output logic [2*DATA_W-1:0] rdDataA,
  input  logic                rdWideB,
  input  logic [3:0]          rdSelB,
  output logic [2*DATA_W-1:0] rdDataB,
  input  logic                wrEn,
  input  logic                wrWide,
  input  logic [3:0]          wrSel,
  input  logic [2*DATA_W-1:0] wrData,
  input  logic                exAf,
  input  logic                exGp
);

  wr_strobe_t strobe;
  logic       afBank;
  logic       gpBank;
  logic [1:0][2*DATA_W-1:0] rdData;

  regfile_ctrl i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrWide (wrWide),
    .wrSel  (wrSel),
    .exAf   (exAf),
    .exGp   (exGp),
    .strobe (strobe),
    .afBank (afBank),
    .gpBank (gpBank)
  );

  regfile_dp #(.DATA_W(DATA_W), .NUM_RD(2)) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .afBank (afBank),
    .gpBank (gpBank),
    .wrData (wrData),
    .rdWide ({rdWideB, rdWideA}),
    .rdSel  ({rdSelB, rdSelA}),
    .rdData (rdData)
  );

  assign rdDataA = rdData[0];
  assign rdDataB = rdData[1];

endmodule

// File: rtl/regfile_xchg_chk.sv
module regfile_xchg_chk #(
  parameter int DATA_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                rdWideA,
  input logic [3:0]          rdSelA,
  input logic [2*DATA_W-1:0] rdDataA,
  input logic                wrEn,
  input logic                wrWide,
  input logic [3:0]          wrSel,
  input logic                exAf,
  input logic                exGp
);

  logic idleWr;
  assign idleWr = !wrEn || (wrWide ? wrSel[3] : (wrSel > 4'd13));

  // R1
  reset_zero_chk: assert property (@(posedge clk) !rstN |-> (rdDataA == '0));

  // R5 R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(exAf) && !$past(exGp) && $past(idleWr) && $stable(rdSelA) && $stable(rdWideA))
    |-> $stable(rdDataA));

  // R8
  index_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (($past(exAf) || $past(exGp)) && !$past(wrEn) && rdWideA && rdSelA == 4'd4
     && $past(rdWideA) && $past(rdSelA) == 4'd4) |-> $stable(rdDataA));

  // R7
  gp_swap_af_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(exGp) && !$past(exAf) && !$past(wrEn) && rdWideA && rdSelA == 4'd3
     && $past(rdWideA) && $past(rdSelA) == 4'd3) |-> $stable(rdDataA));

  // R9
  af_twice_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(exAf, 1) && $past(exAf, 2) && !$past(exGp, 1) && !$past(exGp, 2)
     && !$past(wrEn, 1) && !$past(wrEn, 2) && rdWideA && rdSelA == 4'd3
     && $past(rdWideA, 2) && $past(rdSelA, 2) == 4'd3) |-> (rdDataA == $past(rdDataA, 2)));

endmodule

bind regfile_xchg regfile_xchg_chk #(.DATA_W(DATA_W)) i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .rdWideA (rdWideA),
  .rdSelA  (rdSelA),
  .rdDataA (rdDataA),
  .wrEn    (wrEn),
  .wrWide  (wrWide),
  .wrSel   (wrSel),
  .exAf    (exAf),
  .exGp    (exGp)
);

// File: tb/test_regfile_xchg.sv
module test_regfile_xchg;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rdWideA = 1'b0, rdWideB = 1'b0;
  logic [3:0]  rdSelA = '0, rdSelB = '0;
  logic [15:0] rdDataA, rdDataB;
  logic        wrEn = 1'b0, wrWide = 1'b0, exAf = 1'b0, exGp = 1'b0;
  logic [3:0]  wrSel = '0;
  logic [15:0] wrData = '0;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // Bench model
  logic [7:0] mGp [2][6];
  logic [7:0] mAf [2][2]; // [0]=A [1]=F
  logic [7:0] mIdx [6];
  logic       mAb = 1'b0, mGb = 1'b0;

  always #4 clk = ~clk;

  regfile_xchg i_regfile_xchg (
    .clk(clk), .rstN(rstN),
    .rdWideA(rdWideA), .rdSelA(rdSelA), .rdDataA(rdDataA),
    .rdWideB(rdWideB), .rdSelB(rdSelB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrWide(wrWide), .wrSel(wrSel), .wrData(wrData),
    .exAf(exAf), .exGp(exGp)
  );

  function automatic logic [7:0] mByte(input int code);
    if (code < 6) return mGp[mGb][code];
    if (code == 6) return mAf[mAb][0];
    if (code == 7) return mAf[mAb][1];
    if (code < 14) return mIdx[code-8];
    return 8'h00;
  endfunction

  function automatic logic [15:0] mRead(input logic wide, input logic [3:0] sel);
    if (!wide) return {8'h00, mByte(int'(sel))};
    if (sel[3] || sel == 4'd7) return 16'h0000;
    return {mByte(2*int'(sel)), mByte(2*int'(sel)+1)};
  endfunction

  function automatic void mPut(input int code, input logic [7:0] v);
    if (code < 6) mGp[mGb][code] = v;
    else if (code == 6) mAf[mAb][0] = v;
    else if (code == 7) mAf[mAb][1] = v;
    else if (code < 14) mIdx[code-8] = v;
  endfunction

  function automatic void mWrite(input logic wide, input logic [3:0] sel, input logic [15:0] d);
    if (!wide) mPut(int'(sel), d[7:0]);
    else if (!sel[3]) begin
      mPut(2*int'(sel), d[15:8]);
      mPut(2*int'(sel)+1, d[7:0]);
    end
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // One clock edge with the given stimulus; called and returns at a falling edge
  task automatic step(input logic we, input logic wide, input logic [3:0] sel,
                      input logic [15:0] d, input logic xa, input logic xg);
    wrEn = we; wrWide = wide; wrSel = sel; wrData = d; exAf = xa; exGp = xg;
    @(posedge clk);
    if (we) mWrite(wide, sel, d);
    if (xa) mAb = ~mAb;
    if (xg) mGb = ~mGb;
    @(negedge clk);
    wrEn = 1'b0; exAf = 1'b0; exGp = 1'b0;
  endtask

  // Sweep every code in both widths on both ports
  task automatic sweep(input string tag);
    for (int s = 0; s < 16; s++) begin
      for (int w = 0; w < 2; w++) begin
        rdSelA = 4'(s); rdWideA = w[0];
        rdSelB = 4'(15 - s); rdWideB = ~w[0];
        #1;
        chk({tag, " portA"}, rdDataA, mRead(rdWideA, rdSelA));
        chk({tag, " portB (R4)"}, rdDataB, mRead(rdWideB, rdSelB));
      end
    end
  endtask

  task automatic readA(input logic wide, input logic [3:0] sel);
    rdWideA = wide; rdSelA = sel; #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 2; b++) begin
      for (int i = 0; i < 6; i++) mGp[b][i] = 8'h00;
      for (int i = 0; i < 2; i++) mAf[b][i] = 8'h00;
    end
    for (int i = 0; i < 6; i++) mIdx[i] = 8'h00;

    // R1: reset state
    repeat (3) @(negedge clk);
    sweep("R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    sweep("R1 after reset");

    // R2 R12: byte writes to every code
    for (int c = 0; c < 16; c++) step(1'b1, 1'b0, 4'(c), 16'hFF00 | 16'((c * 37 + 5) & 8'hFF), 1'b0, 1'b0);
    sweep("R2 R12 byte writes");

    // R3: pair writes, high byte first-named
    for (int p = 0; p < 7; p++) step(1'b1, 1'b1, 4'(p), 16'(p * 16'h1357 + 16'h0A0B), 1'b0, 1'b0);
    sweep("R3 pair writes");
    readA(1'b0, 4'd0); chk("R3 B is BC high", rdDataA, 16'h000A);
    readA(1'b0, 4'd1); chk("R3 C is BC low", rdDataA, 16'h000B);

    // R11: writes to unused codes change nothing
    step(1'b1, 1'b0, 4'd14, 16'h7777, 1'b0, 1'b0);
    step(1'b1, 1'b0, 4'd15, 16'h7777, 1'b0, 1'b0);
    for (int p = 7; p < 16; p++) step(1'b1, 1'b1, 4'(p), 16'h8888, 1'b0, 1'b0);
    sweep("R11 unused codes");

    // R5: write visible only after the edge
    rdWideA = 1'b0; rdSelA = 4'd4;
    wrEn = 1'b1; wrWide = 1'b0; wrSel = 4'd4; wrData = 16'h005A;
    #1; chk("R5 before edge", rdDataA, mRead(1'b0, 4'd4));
    @(posedge clk); mWrite(1'b0, 4'd4, 16'h005A);
    #1; chk("R5 after edge", rdDataA, 16'h005A);
    @(negedge clk); wrEn = 1'b0;

    // R6: AF exchange; alternate bank starts at zero
    step(1'b0, 1'b0, 4'd0, 16'h0, 1'b1, 1'b0);
    sweep("R6 R8 AF exchange");
    readA(1'b1, 4'd3); chk("R6 AF alternate is zero", rdDataA, 16'h0000);
    step(1'b1, 1'b1, 4'd3, 16'hC3A1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 4'd0, 16'h0, 1'b1, 1'b0);
    sweep("R6 R9 AF back");

    // R7: GP exchange
    step(1'b0, 1'b0, 4'd0, 16'h0, 1'b0, 1'b1);
    sweep("R7 R8 GP exchange");
    for (int p = 0; p < 3; p++) step(1'b1, 1'b1, 4'(p), 16'(16'hB000 + p * 16'h0111), 1'b0, 1'b0);
    step(1'b0, 1'b0, 4'd0, 16'h0, 1'b0, 1'b1);
    sweep("R7 R9 GP back");
    step(1'b0, 1'b0, 4'd0, 16'h0, 1'b0, 1'b1);
    readA(1'b1, 4'd2); chk("R7 HL alternate", rdDataA, 16'hB222);
    readA(1'b1, 4'd4); chk("R8 IX kept", rdDataA, mRead(1'b1, 4'd4));

    // R9: example values
    step(1'b1, 1'b1, 4'd3, 16'h5944, 1'b0, 1'b0);
    step(1'b0, 1'b0, 4'd0, 16'h0, 1'b1, 1'b0);
    step(1'b1, 1'b1, 4'd3, 16'h9900, 1'b0, 1'b0);
    step(1'b0, 1'b0, 4'd0, 16'h0, 1'b1, 1'b0);
    readA(1'b1, 4'd3); chk("R9 one swap", rdDataA, 16'h5944);
    step(1'b0, 1'b0, 4'd0, 16'h0, 1'b1, 1'b0);
    readA(1'b1, 4'd3); chk("R9 two swaps", rdDataA, 16'h9900);
    // R9: back-to-back swaps with AF selected
    exAf = 1'b1;
    @(posedge clk); mAb = ~mAb;
    @(posedge clk); mAb = ~mAb;
    @(negedge clk); exAf = 1'b0;
    readA(1'b1, 4'd3); chk("R9 back-to-back", rdDataA, 16'h9900);

    // R10: write and exchange in the same cycle
    step(1'b1, 1'b1, 4'd3, 16'hABCD, 1'b1, 1'b0);
    readA(1'b1, 4'd3); chk("R10 AF after write+swap", rdDataA, 16'h5944);
    step(1'b0, 1'b0, 4'd0, 16'h0, 1'b1, 1'b0);
    readA(1'b1, 4'd3); chk("R10 AF back", rdDataA, 16'hABCD);
    step(1'b1, 1'b0, 4'd2, 16'h00EE, 1'b0, 1'b1);
    sweep("R10 GP write+swap");
    step(1'b0, 1'b0, 4'd0, 16'h0, 1'b0, 1'b1);
    readA(1'b0, 4'd2); chk("R10 D in old bank", rdDataA, 16'h00EE);

    // Both exchanges together
    step(1'b0, 1'b0, 4'd0, 16'h0, 1'b1, 1'b1);
    sweep("R6 R7 both swaps");

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule